// File: doc/BRIEF.md
# Six-Step Brushless Motor Commutation Sequencer

This block drives the gate enables of a three-phase half-bridge: three low-side enables and three high-side enables, one pair per motor phase. A commutation tick, typically the output of a phase-locked oscillator that tracks the motor's back-EMF, steps the block through a fixed six-step ring. For every step it also names the one phase that is left floating, so that an external back-EMF sampler knows which winding to observe.

Out of reset the bridge holds an alignment pattern that parks the rotor. The first tick after reset moves the block to an intermediate step with the same pattern. The second tick enters the running ring. On that entry, the phase-3 high-side device switches off while the phase-3 low-side device is due to switch on. The block keeps the low side off until an external status input confirms that the high-side device has released. If that confirmation does not arrive within a bounded number of clock cycles, the block raises a sticky fault and keeps the phase-3 low side off until the next reset.

A low power-enable input blanks all six drives while the sequencer keeps stepping. It also switches the tach output from the commutation tick to an external comparator input, so that a coasting motor can still be timed.

Top module: `bldc_six_step`

## Requirements
- R1: While `rst_n` is low, the outputs show the align pattern straight away, without waiting for a clock edge: high-side enables 3'b101 (phases 1 and 3), low-side enable 3'b010 (phase 2), `smp_vld_o` low, `smp_sel_o` 2'b00 and `hold_fault_o` low.
- R2: After reset is released, the outputs keep the align pattern until the first tick. The first tick moves the block to the intermediate step, which drives the same pattern. The second tick enters step A.
- R3: The running ring is A, B, C, D, E, F and then A again. Low side / high side / sampled phase for each step: A = 3/1/2, B = 3/2/1, C = 1/2/3, D = 1/3/2, E = 2/3/1, F = 2/1/3. Enable bit i-1 stands for phase i. `smp_sel_o` carries the sampled phase number (1 to 3) with `smp_vld_o` high.
- R4: The tick passes through a two-flop synchronizer. Only a rising edge advances the step, so a tick held high advances it exactly once.
- R5: When `pwr_en_i` is low, all six drive enables are low from the next clock edge. The step sequence and the sample select keep running. When the input returns high, the drives of the current step come back on the next clock edge.
- R6: `tach_o` follows `comm_tick_i` while `pwr_en_i` is high and follows `tach_cmp_i` while it is low, with no register in the path.
- R7: No phase ever has its low-side and high-side enables high in the same cycle. The phase-3 low side never turns on in the cycle right after the phase-3 high side was on.
- R8: On entry to step A from the intermediate step, the phase-3 low side stays off until `hs3_off_i` is seen high while the phase-3 high-side enable is already low. It turns on two clock edges after that observation.
- R9: If the release is not seen within `HOLD_MAX` clock cycles of entering A, `hold_fault_o` rises. It stays high until reset, and the phase-3 low side stays off in every step while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces the align step |
| comm_tick_i | input | 1 | Commutation tick, asynchronous to `clk` |
| pwr_en_i | input | 1 | High enables the drives; low blanks them and selects the comparator for tach |
| hs3_off_i | input | 1 | High when the phase-3 high-side device has released |
| tach_cmp_i | input | 1 | External tach comparator input |
| lo_en_o | output | 3 | Low-side enables, bit i-1 for phase i |
| hi_en_o | output | 3 | High-side enables, bit i-1 for phase i |
| smp_sel_o | output | 2 | Floating phase number to sample (1 to 3) |
| smp_vld_o | output | 1 | High when `smp_sel_o` names a phase |
| tach_o | output | 1 | Tick or comparator, chosen by `pwr_en_i` |
| hold_fault_o | output | 1 | Sticky phase-3 release timeout |

## Verification
The properties assume that `pwr_en_i` and `hs3_off_i` are synchronous to `clk`. They also assume that the release status can only be trusted once the phase-3 high-side enable is low, which is why the release is qualified with that enable. The bench changes every input on the falling clock edge. It holds each tick high and low for four cycles, which is longer than the synchronizer's latency, so no tick edge is lost or counted twice. The only asynchronous event in the stimulus is the reset assertion in the middle of a run, which is the case the immediate-reset requirement describes.

// File: rtl/comm_pkg.sv
package comm_pkg;

   typedef enum logic [2:0] {
      ST_ALIGN = 3'd0,
      ST_ZERO  = 3'd1,
      ST_A     = 3'd2,
      ST_B     = 3'd3,
      ST_C     = 3'd4,
      ST_D     = 3'd5,
      ST_E     = 3'd6,
      ST_F     = 3'd7
   } step_e;

   typedef struct packed {
      logic [2:0] lo;
      logic [2:0] hi;
      logic [1:0] sel;
      logic       vld;
   } drive_t;

   localparam drive_t ALIGN_DRIVE = '{lo: 3'b010, hi: 3'b101, sel: 2'd0, vld: 1'b0};

   function automatic step_e next_step(step_e s);
      case (s)
         ST_ALIGN: return ST_ZERO;
         ST_ZERO:  return ST_A;
         ST_A:     return ST_B;
         ST_B:     return ST_C;
         ST_C:     return ST_D;
         ST_D:     return ST_E;
         ST_E:     return ST_F;
         default:  return ST_A;
      endcase
   endfunction

   function automatic drive_t step_drive(step_e s);
      case (s)
         ST_A:    return '{lo: 3'b100, hi: 3'b001, sel: 2'd2, vld: 1'b1};
         ST_B:    return '{lo: 3'b100, hi: 3'b010, sel: 2'd1, vld: 1'b1};
         ST_C:    return '{lo: 3'b001, hi: 3'b010, sel: 2'd3, vld: 1'b1};
         ST_D:    return '{lo: 3'b001, hi: 3'b100, sel: 2'd2, vld: 1'b1};
         ST_E:    return '{lo: 3'b010, hi: 3'b100, sel: 2'd1, vld: 1'b1};
         ST_F:    return '{lo: 3'b010, hi: 3'b001, sel: 2'd3, vld: 1'b1};
         default: return ALIGN_DRIVE;
      endcase
   endfunction

endpackage

// File: rtl/comm_tick_sync.sv
module comm_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic rise_o
);
   localparam int LAST = STAGES;

   logic [LAST:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[LAST-1:0], tick_i};
      end
   end

   assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/comm_step_fsm.sv
module comm_step_fsm
   import comm_pkg::*;
#(
   parameter int HOLD_MAX = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  adv_i,
   input  logic  p3_drv_i,
   input  logic  hs3_off_i,
   output step_e step_o,
   output logic  hold_o,
   output logic  fault_o
);
   localparam int CNT_W = $clog2(HOLD_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_MAX - 1);

   step_e            step_q;
   logic             hold_q;
   logic             fault_q;
   logic [CNT_W-1:0] cnt_q;
   logic             released;

   assign released = !p3_drv_i && hs3_off_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= ST_ALIGN;
         hold_q  <= 1'b0;
         fault_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (adv_i) begin
            step_q <= next_step(step_q);
         end
         if (adv_i && step_q == ST_ZERO) begin
            hold_q <= 1'b1;
            cnt_q  <= '0;
         end else if (hold_q) begin
            if (released) begin
               hold_q <= 1'b0;
            end else if (cnt_q == CNT_LAST) begin
               hold_q  <= 1'b0;
               fault_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign step_o  = step_q;
   assign hold_o  = hold_q;
   assign fault_o = fault_q;
endmodule

// File: rtl/comm_drive_map.sv
module comm_drive_map
   import comm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  step_e      step_i,
   input  logic       hold_i,
   input  logic       fault_i,
   input  logic       pwr_en_i,
   output logic [2:0] lo_o,
   output logic [2:0] hi_o,
   output logic [1:0] sel_o,
   output logic       vld_o
);
   drive_t d_next;
   drive_t d_q;

   always_comb begin
      d_next = step_drive(step_i);
      if (hold_i || fault_i) begin
         d_next.lo[2] = 1'b0;
      end
      if (!pwr_en_i) begin
         d_next.lo = 3'b000;
         d_next.hi = 3'b000;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_q <= ALIGN_DRIVE;
      end else begin
         d_q <= d_next;
      end
   end

   assign lo_o  = d_q.lo;
   assign hi_o  = d_q.hi;
   assign sel_o = d_q.sel;
   assign vld_o = d_q.vld;
endmodule

// File: rtl/bldc_six_step.sv
module bldc_six_step
   import comm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_MAX    = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       comm_tick_i,
   input  logic       pwr_en_i,
   input  logic       hs3_off_i,
   input  logic       tach_cmp_i,
   output logic [2:0] lo_en_o,
   output logic [2:0] hi_en_o,
   output logic [1:0] smp_sel_o,
   output logic       smp_vld_o,
   output logic       tach_o,
   output logic       hold_fault_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (HOLD_MAX < 2) begin : g_bad_hold
         $error("HOLD_MAX must be at least 2");
      end
   endgenerate

   logic  adv;
   step_e step;
   logic  hold;

   comm_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (comm_tick_i),
      .rise_o (adv)
   );

   comm_step_fsm #(.HOLD_MAX(HOLD_MAX)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (adv),
      .p3_drv_i  (hi_en_o[2]),
      .hs3_off_i (hs3_off_i),
      .step_o    (step),
      .hold_o    (hold),
      .fault_o   (hold_fault_o)
   );

   comm_drive_map u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step),
      .hold_i   (hold),
      .fault_i  (hold_fault_o),
      .pwr_en_i (pwr_en_i),
      .lo_o     (lo_en_o),
      .hi_o     (hi_en_o),
      .sel_o    (smp_sel_o),
      .vld_o    (smp_vld_o)
   );

   assign tach_o = pwr_en_i ? comm_tick_i : tach_cmp_i;
endmodule

// File: rtl/bldc_six_step_chk.sv
module bldc_six_step_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_en_i,
   input logic [2:0] lo_en_o,
   input logic [2:0] hi_en_o,
   input logic [1:0] smp_sel_o,
   input logic       smp_vld_o,
   input logic       hold_fault_o
);
   // R1: the cycle reset lifts, the align pattern is still shown
   p_align_at_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (hi_en_o == 3'b101 && lo_en_o == 3'b010 && !smp_vld_o && !hold_fault_o));

   // R3: a valid select names a phase number
   p_sel_named_r3: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld_o |-> (smp_sel_o != 2'd0));

   // R3: the sampled phase is driven by neither side
   p_sel_floating_r3: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld_o |-> ((((lo_en_o | hi_en_o) >> (smp_sel_o - 2'd1)) & 3'b001) == 3'b000));

   // R5: power disable blanks all drives at the next edge
   p_blank_on_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en_i |=> (lo_en_o == 3'b000 && hi_en_o == 3'b000));

   // R7: no shoot-through on any phase
   p_no_shoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_en_o & hi_en_o) == 3'b000);

   // R7: phase-3 low side never follows its high side directly
   p_n3_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_en_o[2]) |-> !$past(hi_en_o[2]));

   // R9: the fault is sticky
   p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_fault_o |=> hold_fault_o);

   // R9: the phase-3 low side stays off while the fault is up
   p_fault_n3_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_fault_o |-> !lo_en_o[2]);
endmodule

bind bldc_six_step bldc_six_step_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_en_i     (pwr_en_i),
   .lo_en_o      (lo_en_o),
   .hi_en_o      (hi_en_o),
   .smp_sel_o    (smp_sel_o),
   .smp_vld_o    (smp_vld_o),
   .hold_fault_o (hold_fault_o)
);

// File: tb/bldc_six_step_bench.sv
`timescale 1ns/1ps
module bldc_six_step_bench;
   localparam int HOLD = 16;
   localparam logic [8:0] ALIGN_V = {3'b010, 3'b101, 2'd0, 1'b0};

   logic clk = 1'b0;
   logic rst_n, tick, pwr_en, hs3_off, tcmp;
   logic [2:0] lo, hi;
   logic [1:0] sel;
   logic vld, tach, fault;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bldc_six_step #(.SYNC_STAGES(2), .HOLD_MAX(HOLD)) u_bldc_six_step (
      .clk(clk), .rst_n(rst_n), .comm_tick_i(tick), .pwr_en_i(pwr_en),
      .hs3_off_i(hs3_off), .tach_cmp_i(tcmp), .lo_en_o(lo), .hi_en_o(hi),
      .smp_sel_o(sel), .smp_vld_o(vld), .tach_o(tach), .hold_fault_o(fault)
   );

   function automatic logic [8:0] exp_run(int k);
      int n, p, s;
      logic [2:0] le, he;
      n = ((k / 2) + 2) % 3 + 1;
      p = (((k + 1) / 2) % 3) + 1;
      s = 6 - n - p;
      le = 3'b001 << (n - 1);
      he = 3'b001 << (p - 1);
      return {le, he, 2'(s), 1'b1};
   endfunction

   task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_tick();
      tick = 1'b1;
      cyc(4);
      tick = 1'b0;
      cyc(4);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   initial begin
      rst_n = 1'b0; tick = 1'b0; pwr_en = 1'b1; hs3_off = 1'b1; tcmp = 1'b0;
      cyc(4);
      chk("R1 reset pattern", {lo, hi, sel, vld}, ALIGN_V);
      chk("R1 reset fault", {8'd0, fault}, 9'd0);
      rst_n = 1'b1;
      cyc(6);
      chk("R2 align held", {lo, hi, sel, vld}, ALIGN_V);
      do_tick();
      chk("R2 intermediate step", {lo, hi, sel, vld}, ALIGN_V);
      do_tick();
      chk("R2 enter A", {lo, hi, sel, vld}, exp_run(0));
      for (int k = 1; k <= 18; k++) begin
         do_tick();
         chk("R3 ring step", {lo, hi, sel, vld}, exp_run(k % 6));
      end
      // R4: tick held high advances once
      tick = 1'b1;
      cyc(20);
      chk("R4 held tick", {lo, hi, sel, vld}, exp_run(1));
      tick = 1'b0;
      cyc(6);
      chk("R4 falling edge", {lo, hi, sel, vld}, exp_run(1));
      // R5 and R6: power disable
      pwr_en = 1'b0;
      cyc(2);
      chk("R5 blanked", {lo, hi, sel, vld}, {6'd0, exp_run(1)[2:0]});
      tcmp = 1'b1; #1;
      chk("R6 tach cmp high", {8'd0, tach}, 9'd1);
      tcmp = 1'b0; #1;
      chk("R6 tach cmp low", {8'd0, tach}, 9'd0);
      do_tick();
      chk("R5 steps while blanked", {lo, hi, sel, vld}, {6'd0, exp_run(2)[2:0]});
      pwr_en = 1'b1;
      cyc(2);
      chk("R5 restored", {lo, hi, sel, vld}, exp_run(2));
      tick = 1'b1; #1;
      chk("R6 tach follows tick", {8'd0, tach}, 9'd1);
      cyc(4);
      tick = 1'b0;
      cyc(4);
      chk("R3 step after tach", {lo, hi, sel, vld}, exp_run(3));
      // R1: reset acts immediately
      #1 rst_n = 1'b0;
      #0.5;
      chk("R1 async reset", {lo, hi, sel, vld}, ALIGN_V);
      cyc(2);
      rst_n = 1'b1;
      cyc(2);
      // R8: hold-off until release
      hs3_off = 1'b0;
      do_tick();
      do_tick();
      chk("R8 N3 held off", {lo, hi, sel, vld}, {3'b000, 3'b001, 2'd2, 1'b1});
      chk("R8 no fault yet", {8'd0, fault}, 9'd0);
      hs3_off = 1'b1;
      cyc(3);
      chk("R8 N3 after release", {lo, hi, sel, vld}, exp_run(0));
      chk("R9 no fault on release", {8'd0, fault}, 9'd0);
      // R9: timeout
      hs3_off = 1'b0;
      do_reset();
      do_tick();
      do_tick();
      chk("R9 before timeout", {8'd0, fault}, 9'd0);
      cyc(HOLD + 4);
      chk("R9 fault raised", {8'd0, fault}, 9'd1);
      chk("R9 N3 off at fault", {lo, hi, sel, vld}, {3'b000, 3'b001, 2'd2, 1'b1});
      hs3_off = 1'b1;
      cyc(4);
      chk("R9 late release ignored", {lo, hi, sel, vld}, {3'b000, 3'b001, 2'd2, 1'b1});
      do_tick();
      chk("R9 N3 off in B", {lo, hi, sel, vld}, {3'b000, 3'b010, 2'd1, 1'b1});
      chk("R9 fault sticky", {8'd0, fault}, 9'd1);
      do_reset();
      chk("R1 fault cleared", {8'd0, fault}, 9'd0);
      chk("R7 align no overlap", {6'd0, lo & hi}, 9'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule